// File: doc/BRIEF.md
# Prioritized interrupt class arbiter

This block decides which asynchronous interrupt class a processor core takes next. It keeps a depth count for the machine-check queue, the external queue and each I/O subclass queue. It holds sticky pending flags for the clock-comparator and CPU-timer sources. When the core raises a deliver request, the block picks one class in fixed priority order. The choice honours the enable bits of the current status word, the per-subclass I/O enable mask and the machine-check reporting enable. The block then emits a one-cycle delivery strobe with the chosen class and its interruption code.

The core drives the status-word enable bits and the two control-register fields straight into the block. Queue producers pulse a push input for each new entry. The clock-comparator and CPU-timer sources pulse their own inputs. The core only raises a deliver request at an instruction boundary. A latched synchronous exception, such as a program check or a supervisor call, always wins, and the block then delivers nothing. The payload storage of the external queue lives outside the block, which receives the code of the head entry on `ext_head_code`. Writing the old and new status words to memory is the core's job.

Top module: `irq_class_arbiter`

## Requirements
- R1: After reset every queue depth is zero and every pending flag is clear. `irq`, `dlv_valid` and `ovf_err` are 0, and `dlv_class` is 0 (none).
- R2: While `sync_hold` is 1, a deliver request delivers nothing and changes no queue or pending state.
- R3: Machine checks have the highest priority and are considered only when `mask_mchk` is 1. A delivered machine check has class 1 and code 64'h00400f1d_40330000, and it removes one entry.
- R4: When the machine-check class is selected but `mchk_report_en` is 0, nothing is delivered in that request, not even a lower class. The entry stays queued.
- R5: External interrupts come second and are considered only when `mask_ext` is 1, with class 2. A queued entry wins first, with code `ext_head_code` zero-extended. The clock comparator comes next with code 16'h1004, and the CPU timer last with code 16'h1005. Delivering a timer source clears its pending flag, unless a new pulse arrives in the same cycle.
- R6: I/O comes last and is considered only when `mask_io` is 1 and the I/O pending flag is set, with class 3. Subclass s is enabled by `io_sub_mask[s]`. The lowest-numbered subclass that is enabled and non-empty is delivered, with code s, and loses one entry. Disabled subclasses keep their entries.
- R7: Any I/O push sets the I/O pending flag. An I/O selection clears the flag only when every subclass queue is empty after that delivery.
- R8: The external and machine-check classes count as pending exactly while their queue depth is at least one.
- R9: Each queue depth saturates at 2**DEPTH_W-1. A push into a full queue with no pop in the same cycle is dropped and sets the sticky `ovf_err`, which only reset clears. A push and a pop in the same cycle leave the depth unchanged.
- R10: `irq` is the OR over the classes of each pending condition ANDed with its status-word mask, computed from the registered state. It drops in the cycle after the last enabled pending condition clears.
- R11: `dlv_valid` rises for exactly one cycle, in the cycle after the clock edge that samples a deliver request that results in a delivery. `dlv_class` is 0 whenever `dlv_valid` is 0. The decision uses the state from before that edge, so pushes in the same cycle do not take part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_hold | input | 1 | A synchronous exception is latched and takes precedence |
| deliver_req | input | 1 | The core asks for an interrupt at this boundary |
| mask_mchk | input | 1 | Status-word machine-check enable |
| mask_ext | input | 1 | Status-word external enable |
| mask_io | input | 1 | Status-word I/O enable |
| io_sub_mask | input | NUM_SUB | Per-subclass I/O enable from the control register |
| mchk_report_en | input | 1 | Machine-check reporting enable from the control register |
| push_mchk | input | 1 | One new machine-check entry |
| push_ext | input | 1 | One new external entry |
| ext_head_code | input | 16 | Code of the oldest external entry |
| push_io | input | NUM_SUB | One new entry per flagged subclass |
| clk_cmp_pulse | input | 1 | Clock-comparator match |
| cpu_tmr_pulse | input | 1 | CPU-timer expiry |
| irq | output | 1 | An enabled interrupt is pending |
| dlv_valid | output | 1 | Delivery strobe |
| dlv_class | output | 2 | 0 none, 1 machine check, 2 external, 3 I/O |
| dlv_code | output | 64 | Interruption code of the delivery |
| ovf_err | output | 1 | Sticky queue overflow |

## Verification
The bench builds the block with four I/O subclasses and a two-bit depth, so each queue is full at three entries. With these values, saturation and the sticky overflow are reached after a handful of pushes. Masked-off subclasses, the scan order across all subclasses and the conditional I/O flag clear all fit into short directed sequences. A long random phase mixes masks, pushes and requests, so that priority collisions between all classes occur at full queues and at empty ones.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_MCHK = 2'd1,
    CLS_EXT  = 2'd2,
    CLS_IO   = 2'd3
  } irq_cls_e;

  localparam int          CODE_W          = 64;
  localparam int          EXT_CODE_W      = 16;
  localparam logic [15:0] EXT_CODE_CLKCMP = 16'h1004;
  localparam logic [15:0] EXT_CODE_CPUTMR = 16'h1005;
  localparam logic [63:0] MCHK_CODE       = 64'h00400f1d_40330000;

endpackage

// File: rtl/irq_depth_ctr.sv
module irq_depth_ctr #(
  parameter int DEPTH_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  output logic nonempty,
  output logic last_one,
  output logic ovf_hit
);

  localparam logic [DEPTH_W-1:0] FULL = '1;
  localparam logic [DEPTH_W-1:0] ONE  = DEPTH_W'(1);

  logic [DEPTH_W-1:0] cnt_q;
  logic [DEPTH_W-1:0] cnt_d;
  logic               cnt_en;

  always_comb begin
    cnt_d   = cnt_q;
    ovf_hit = 1'b0;
    case ({push, pop})
      2'b10: begin
        if (cnt_q == FULL) ovf_hit = 1'b1;
        else               cnt_d   = cnt_q + ONE;
      end
      2'b01: begin
        if (cnt_q != '0) cnt_d = cnt_q - ONE;
      end
      default: ;
    endcase
    cnt_en = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign nonempty = (cnt_q != '0);
  assign last_one = (cnt_q == ONE);

endmodule

// File: rtl/io_subclass_pick.sv
module io_subclass_pick #(
  parameter int NUM_SUB = 8,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_SUB-1:0] enabled,
  input  logic [NUM_SUB-1:0] nonempty,
  output logic               found,
  output logic [IDX_W-1:0]   idx,
  output logic [NUM_SUB-1:0] grant
);

  // lowest index wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    grant = '0;
    for (int s = 0; s < NUM_SUB; s++) begin
      if (!found && enabled[s] && nonempty[s]) begin
        found    = 1'b1;
        idx      = IDX_W'(s);
        grant[s] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_class_sel.sv
module irq_class_sel
  import irq_arb_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic                  deliver_req,
  input  logic                  sync_hold,
  input  logic                  mask_mchk,
  input  logic                  mask_ext,
  input  logic                  mask_io,
  input  logic                  mchk_report_en,
  input  logic                  mchk_ne,
  input  logic                  ext_ne,
  input  logic                  clk_cmp_pend,
  input  logic                  cpu_tmr_pend,
  input  logic                  io_pend,
  input  logic                  io_found,
  input  logic [IDX_W-1:0]      io_idx,
  input  logic [EXT_CODE_W-1:0] ext_head_code,
  output logic                  take,
  output irq_cls_e              cls,
  output logic [CODE_W-1:0]     code,
  output logic                  pop_mchk,
  output logic                  pop_ext,
  output logic                  clr_clk_cmp,
  output logic                  clr_cpu_tmr,
  output logic                  pop_io,
  output logic                  io_scan
);

  logic arb_open;
  assign arb_open = deliver_req && !sync_hold;

  always_comb begin
    take        = 1'b0;
    cls         = CLS_NONE;
    code        = '0;
    pop_mchk    = 1'b0;
    pop_ext     = 1'b0;
    clr_clk_cmp = 1'b0;
    clr_cpu_tmr = 1'b0;
    pop_io      = 1'b0;
    io_scan     = 1'b0;
    if (arb_open) begin
      if (mask_mchk && mchk_ne) begin
        // selected class blocks lower classes even when not reportable
        if (mchk_report_en) begin
          take     = 1'b1;
          cls      = CLS_MCHK;
          code     = MCHK_CODE;
          pop_mchk = 1'b1;
        end
      end else if (mask_ext && (ext_ne || clk_cmp_pend || cpu_tmr_pend)) begin
        take = 1'b1;
        cls  = CLS_EXT;
        if (ext_ne) begin
          pop_ext = 1'b1;
          code    = CODE_W'(ext_head_code);
        end else if (clk_cmp_pend) begin
          clr_clk_cmp = 1'b1;
          code        = CODE_W'(EXT_CODE_CLKCMP);
        end else begin
          clr_cpu_tmr = 1'b1;
          code        = CODE_W'(EXT_CODE_CPUTMR);
        end
      end else if (mask_io && io_pend) begin
        io_scan = 1'b1;
        if (io_found) begin
          take   = 1'b1;
          cls    = CLS_IO;
          code   = CODE_W'(io_idx);
          pop_io = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/irq_class_arbiter.sv
module irq_class_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SUB = 8,
  parameter int DEPTH_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_hold,
  input  logic               deliver_req,
  input  logic               mask_mchk,
  input  logic               mask_ext,
  input  logic               mask_io,
  input  logic [NUM_SUB-1:0] io_sub_mask,
  input  logic               mchk_report_en,
  input  logic               push_mchk,
  input  logic               push_ext,
  input  logic [15:0]        ext_head_code,
  input  logic [NUM_SUB-1:0] push_io,
  input  logic               clk_cmp_pulse,
  input  logic               cpu_tmr_pulse,
  output logic               irq,
  output logic               dlv_valid,
  output logic [1:0]         dlv_class,
  output logic [63:0]        dlv_code,
  output logic               ovf_err
);

  localparam int IDX_W = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  // queue depth counters
  logic               mchk_ne, mchk_last, mchk_ovf, pop_mchk;
  logic               ext_ne, ext_last, ext_ovf, pop_ext;
  logic [NUM_SUB-1:0] io_ne, io_last, io_ovf, io_pop, io_grant;

  irq_depth_ctr #(.DEPTH_W(DEPTH_W)) u_mchk_ctr (
    .clk(clk), .rst_n(rst_n_s), .push(push_mchk), .pop(pop_mchk),
    .nonempty(mchk_ne), .last_one(mchk_last), .ovf_hit(mchk_ovf)
  );

  irq_depth_ctr #(.DEPTH_W(DEPTH_W)) u_ext_ctr (
    .clk(clk), .rst_n(rst_n_s), .push(push_ext), .pop(pop_ext),
    .nonempty(ext_ne), .last_one(ext_last), .ovf_hit(ext_ovf)
  );

  for (genvar s = 0; s < NUM_SUB; s++) begin : g_io_q
    irq_depth_ctr #(.DEPTH_W(DEPTH_W)) u_io_ctr (
      .clk(clk), .rst_n(rst_n_s), .push(push_io[s]), .pop(io_pop[s]),
      .nonempty(io_ne[s]), .last_one(io_last[s]), .ovf_hit(io_ovf[s])
    );
  end

  // subclass scan
  logic             io_found;
  logic [IDX_W-1:0] io_idx;

  io_subclass_pick #(.NUM_SUB(NUM_SUB), .IDX_W(IDX_W)) u_pick (
    .enabled(io_sub_mask), .nonempty(io_ne),
    .found(io_found), .idx(io_idx), .grant(io_grant)
  );

  // class selection
  logic              clk_cmp_q, cpu_tmr_q, io_pend_q;
  logic              take, clr_clk_cmp, clr_cpu_tmr, pop_io, io_scan;
  irq_cls_e          sel_cls;
  logic [CODE_W-1:0] sel_code;

  irq_class_sel #(.IDX_W(IDX_W)) u_sel (
    .deliver_req(deliver_req), .sync_hold(sync_hold),
    .mask_mchk(mask_mchk), .mask_ext(mask_ext), .mask_io(mask_io),
    .mchk_report_en(mchk_report_en),
    .mchk_ne(mchk_ne), .ext_ne(ext_ne),
    .clk_cmp_pend(clk_cmp_q), .cpu_tmr_pend(cpu_tmr_q), .io_pend(io_pend_q),
    .io_found(io_found), .io_idx(io_idx), .ext_head_code(ext_head_code),
    .take(take), .cls(sel_cls), .code(sel_code),
    .pop_mchk(pop_mchk), .pop_ext(pop_ext),
    .clr_clk_cmp(clr_clk_cmp), .clr_cpu_tmr(clr_cpu_tmr),
    .pop_io(pop_io), .io_scan(io_scan)
  );

  assign io_pop = pop_io ? io_grant : '0;

  // every subclass empty once this cycle's pop lands
  logic io_drained;
  always_comb begin
    io_drained = 1'b1;
    for (int s = 0; s < NUM_SUB; s++) begin
      if (io_ne[s] && !(io_last[s] && io_pop[s])) io_drained = 1'b0;
    end
  end

  // next state
  logic              clk_cmp_d, cpu_tmr_d, io_pend_d, ovf_d;
  logic              dlv_valid_q;
  irq_cls_e          dlv_cls_q, dlv_cls_d;
  logic [CODE_W-1:0] dlv_code_q;
  logic              code_en;

  always_comb begin
    clk_cmp_d = clk_cmp_pulse | (clk_cmp_q & ~clr_clk_cmp);
    cpu_tmr_d = cpu_tmr_pulse | (cpu_tmr_q & ~clr_cpu_tmr);
    io_pend_d = (|push_io) | (io_pend_q & ~(io_scan & io_drained));
    ovf_d     = ovf_err | mchk_ovf | ext_ovf | (|io_ovf);
    dlv_cls_d = take ? sel_cls : CLS_NONE;
    code_en   = take;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      clk_cmp_q   <= 1'b0;
      cpu_tmr_q   <= 1'b0;
      io_pend_q   <= 1'b0;
      ovf_err     <= 1'b0;
      dlv_valid_q <= 1'b0;
      dlv_cls_q   <= CLS_NONE;
    end else begin
      clk_cmp_q   <= clk_cmp_d;
      cpu_tmr_q   <= cpu_tmr_d;
      io_pend_q   <= io_pend_d;
      ovf_err     <= ovf_d;
      dlv_valid_q <= take;
      dlv_cls_q   <= dlv_cls_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     dlv_code_q <= '0;
    else if (code_en) dlv_code_q <= sel_code;
  end

  assign dlv_valid = dlv_valid_q;
  assign dlv_class = dlv_cls_q;
  assign dlv_code  = dlv_code_q;

  assign irq = (mask_mchk & mchk_ne)
             | (mask_ext & (ext_ne | clk_cmp_q | cpu_tmr_q))
             | (mask_io & io_pend_q);

endmodule

// File: rtl/irq_class_arbiter_chk.sv
module irq_class_arbiter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        deliver_req,
  input logic        sync_hold,
  input logic        mask_mchk,
  input logic        mask_ext,
  input logic        mask_io,
  input logic        mchk_report_en,
  input logic        irq,
  input logic        dlv_valid,
  input logic [1:0]  dlv_class,
  input logic [63:0] dlv_code,
  input logic        ovf_err
);

  AST_DLV_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> ($past(deliver_req) && !$past(sync_hold))); // R2

  AST_NONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dlv_valid |-> (dlv_class == 2'd0)); // R11

  AST_MCHK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_class == 2'd1) |-> (dlv_code == 64'h00400f1d_40330000)); // R3

  AST_MCHK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_class == 2'd1) |-> ($past(mchk_report_en) && $past(mask_mchk))); // R4

  AST_EXT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_class == 2'd2) |-> $past(mask_ext)); // R5

  AST_IO_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_class == 2'd3) |-> $past(mask_io)); // R6

  AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err); // R9

  AST_IRQ_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_mchk && !mask_ext && !mask_io) |-> !irq); // R10

endmodule

bind irq_class_arbiter irq_class_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .deliver_req(deliver_req), .sync_hold(sync_hold),
  .mask_mchk(mask_mchk), .mask_ext(mask_ext), .mask_io(mask_io),
  .mchk_report_en(mchk_report_en), .irq(irq), .dlv_valid(dlv_valid),
  .dlv_class(dlv_class), .dlv_code(dlv_code), .ovf_err(ovf_err)
);

// File: tb/irq_class_arbiter_test.sv
`timescale 1ns/1ps
module irq_class_arbiter_test;

  localparam int NS   = 4;
  localparam int DW   = 2;
  localparam int MAXD = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sync_hold, deliver_req, mask_mchk, mask_ext, mask_io;
  logic [NS-1:0] io_sub_mask, push_io;
  logic          mchk_report_en, push_mchk, push_ext, clk_cmp_pulse, cpu_tmr_pulse;
  logic [15:0]   ext_head_code;
  logic          irq, dlv_valid, ovf_err;
  logic [1:0]    dlv_class;
  logic [63:0]   dlv_code;

  always #4 clk = ~clk;

  irq_class_arbiter #(.NUM_SUB(NS), .DEPTH_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .sync_hold(sync_hold), .deliver_req(deliver_req),
    .mask_mchk(mask_mchk), .mask_ext(mask_ext), .mask_io(mask_io),
    .io_sub_mask(io_sub_mask), .mchk_report_en(mchk_report_en),
    .push_mchk(push_mchk), .push_ext(push_ext), .ext_head_code(ext_head_code),
    .push_io(push_io), .clk_cmp_pulse(clk_cmp_pulse), .cpu_tmr_pulse(cpu_tmr_pulse),
    .irq(irq), .dlv_valid(dlv_valid), .dlv_class(dlv_class),
    .dlv_code(dlv_code), .ovf_err(ovf_err)
  );

  // reference model state
  int          m_ext, m_mchk;
  int          m_io [NS];
  bit          m_clk, m_tmr, m_iof, m_ovf;
  bit          e_valid;
  int          e_cls;
  logic [63:0] e_code;
  string       e_tag;
  string       cur_req;
  int          vectors, miscompares;
  bit          done;

  function automatic int ctr_next(int d, bit pu, bit po);
    if (pu && !po) begin
      if (d == MAXD) begin m_ovf = 1'b1; return d; end
      return d + 1;
    end
    if (po && !pu) return d - 1;
    return d;
  endfunction

  function automatic void model_reset();
    m_ext = 0; m_mchk = 0; m_clk = 0; m_tmr = 0; m_iof = 0; m_ovf = 0;
    for (int s = 0; s < NS; s++) m_io[s] = 0;
    e_valid = 0; e_cls = 0; e_code = '0; e_tag = "R1";
  endfunction

  function automatic void model_step();
    bit pe = 0, pm = 0, ctod = 0, ccpt = 0, scan = 0;
    int ps = -1;
    e_valid = 0; e_cls = 0; e_tag = "R11";
    if (deliver_req && !sync_hold) begin
      if (mask_mchk && m_mchk > 0) begin
        e_tag = "R4";
        if (mchk_report_en) begin
          e_valid = 1; e_cls = 1; e_code = 64'h00400f1d40330000; pm = 1; e_tag = "R3";
        end
      end else if (mask_ext && (m_ext > 0 || m_clk || m_tmr)) begin
        e_valid = 1; e_cls = 2; e_tag = "R5";
        if (m_ext > 0) begin pe = 1; e_code = {48'h0, ext_head_code}; end
        else if (m_clk) begin ctod = 1; e_code = 64'h1004; end
        else begin ccpt = 1; e_code = 64'h1005; end
      end else if (mask_io && m_iof) begin
        scan = 1; e_tag = "R6";
        for (int s = 0; s < NS; s++)
          if (ps < 0 && io_sub_mask[s] && m_io[s] > 0) ps = s;
        if (ps >= 0) begin e_valid = 1; e_cls = 3; e_code = 64'(ps); end
      end
    end
    if (scan) begin
      int left = 0;
      for (int s = 0; s < NS; s++) left += m_io[s] - ((s == ps) ? 1 : 0);
      if (left == 0) m_iof = 0;
    end
    if (|push_io) m_iof = 1;
    m_clk  = clk_cmp_pulse | (m_clk & !ctod);
    m_tmr  = cpu_tmr_pulse | (m_tmr & !ccpt);
    m_mchk = ctr_next(m_mchk, push_mchk, pm);
    m_ext  = ctr_next(m_ext, push_ext, pe);
    for (int s = 0; s < NS; s++) m_io[s] = ctr_next(m_io[s], push_io[s], s == ps);
  endfunction

  task automatic compare();
    bit   x_irq;
    logic [1:0] x_cls;
    bit   io_any = 0;
    x_irq = (mask_mchk && m_mchk > 0) || (mask_ext && (m_ext > 0 || m_clk || m_tmr))
          || (mask_io && m_iof);
    x_cls = e_valid ? 2'(e_cls) : 2'd0;
    vectors++;
    if (irq !== x_irq) begin
      miscompares++;
      $display("FAIL %s/R10 irq actual=%0b expected=%0b", cur_req, irq, x_irq);
    end
    if (ovf_err !== m_ovf) begin
      miscompares++;
      $display("FAIL %s/R9 ovf_err actual=%0b expected=%0b", cur_req, ovf_err, m_ovf);
    end
    if (dlv_valid !== e_valid) begin
      miscompares++;
      $display("FAIL %s/%s dlv_valid actual=%0b expected=%0b", cur_req, e_tag, dlv_valid, e_valid);
    end
    if (dlv_class !== x_cls) begin
      miscompares++;
      $display("FAIL %s/%s dlv_class actual=%0d expected=%0d", cur_req, e_tag, dlv_class, x_cls);
    end
    if (e_valid && dlv_code !== e_code) begin
      miscompares++;
      $display("FAIL %s/%s dlv_code actual=%h expected=%h", cur_req, e_tag, dlv_code, e_code);
    end
    if (io_any) ;
  endtask

  // one clock: model, edge, sample, drop one-shot inputs
  task automatic tick();
    model_step();
    @(posedge clk);
    #2;
    compare();
    deliver_req = 0; push_mchk = 0; push_ext = 0; push_io = '0;
    clk_cmp_pulse = 0; cpu_tmr_pulse = 0;
  endtask

  task automatic deliver();
    deliver_req = 1;
    tick();
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    vectors = 0; miscompares = 0; done = 0;
    rst_n = 0; sync_hold = 0; deliver_req = 0;
    mask_mchk = 1; mask_ext = 1; mask_io = 1; io_sub_mask = '1; mchk_report_en = 1;
    push_mchk = 0; push_ext = 0; push_io = '0; clk_cmp_pulse = 0; cpu_tmr_pulse = 0;
    ext_head_code = 16'hABCD;
    model_reset();
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    cur_req = "R1";           // reset state
    compare();
    repeat (3) tick();

    // R10: clock comparator pending but external masked
    cur_req = "R10";
    mask_ext = 0; clk_cmp_pulse = 1; tick();
    mask_ext = 1; tick();
    cur_req = "R5";           // clock comparator delivered with its code
    deliver(); tick();

    // R5: queued entries beat clock comparator, which beats CPU timer
    push_ext = 1; clk_cmp_pulse = 1; cpu_tmr_pulse = 1; tick();
    push_ext = 1; tick();
    deliver(); deliver(); deliver(); deliver(); deliver();

    // R2: latched synchronous exception blocks all classes
    cur_req = "R2";
    push_mchk = 1; push_ext = 1; push_io = 4'b0001; tick();
    sync_hold = 1; deliver(); deliver(); sync_hold = 0;

    // R3: machine check first, then external, then I/O
    cur_req = "R3";
    deliver(); deliver(); deliver(); deliver();

    // R4: machine check selected but reporting off blocks lower classes
    cur_req = "R4";
    mchk_report_en = 0; push_mchk = 1; push_ext = 1; tick();
    deliver(); deliver();
    mchk_report_en = 1; deliver(); deliver(); deliver();

    // R6 and R7: disabled subclass keeps the pending flag alive
    cur_req = "R6";
    mask_mchk = 0; mask_ext = 0;
    io_sub_mask = 4'b1101; push_io = 4'b1110; tick();
    deliver(); deliver();
    cur_req = "R7";
    deliver(); tick();
    io_sub_mask = 4'b1111; deliver(); tick();

    // R9: saturation and sticky overflow
    cur_req = "R9";
    for (int k = 0; k < 5; k++) begin push_io = 4'b0001; tick(); end
    push_io = 4'b0001; deliver();
    deliver(); deliver(); deliver(); deliver();

    // R8: machine-check pending follows its depth
    cur_req = "R8";
    mask_mchk = 1; push_mchk = 1; tick(); push_mchk = 1; tick();
    deliver(); tick(); deliver(); tick();

    // R11 and mixed traffic
    cur_req = "R11";
    mask_ext = 1;
    for (int k = 0; k < 600; k++) begin
      mask_mchk      = $urandom_range(0, 3) != 0;
      mask_ext       = $urandom_range(0, 3) != 0;
      mask_io        = $urandom_range(0, 3) != 0;
      mchk_report_en = $urandom_range(0, 4) != 0;
      sync_hold      = $urandom_range(0, 7) == 0;
      io_sub_mask    = 4'($urandom);
      ext_head_code  = 16'($urandom);
      push_mchk      = $urandom_range(0, 7) == 0;
      push_ext       = $urandom_range(0, 4) == 0;
      push_io        = 4'($urandom) & 4'($urandom) & 4'($urandom);
      clk_cmp_pulse  = $urandom_range(0, 9) == 0;
      cpu_tmr_pulse  = $urandom_range(0, 9) == 0;
      deliver_req    = $urandom_range(0, 1) == 1;
      tick();
    end

    done = 1;
    summary();
    $finish;
  end

endmodule